// File: doc/BRIEF.md
# Registered 8-bit ALU with Per-Flag Commit Mask

This block is the arithmetic and logic stage of a small load/store processor core. Each cycle it takes an operation code, two operands and the current carry bit. The operands may come from a register or from an immediate field. It computes a result and the four status bits: negative, zero, carry and overflow.

Alongside the status bits it produces a commit mask. The mask names the status bits that this operation owns, so the status register keeps every bit the operation does not touch. The operation set is:

- add, add with carry, subtract, increment and decrement;
- bitwise and, or and exclusive-or, and one's complement;
- logical shifts in both directions, and rotates through the carry in both directions.

Inputs are captured on a rising clock edge, and all outputs are registered. Multiply, divide, half-carry, the register file and instruction decode belong to other blocks.

Top module: `alu8_core`

## Requirements
- R1: While `rst_n` is low, `res_o`, `flags_o` and `fmask_o` are all zero.
- R2: Flag bits are ordered {N,Z,C,V} at positions 3..0 in both `flags_o` and `fmask_o`. Where a mask bit is set, N equals result bit 7 and Z is 1 exactly when the result is zero. Every flag bit whose mask bit is clear reads 0.
- R3: Opcode 0 adds, 1 adds with the carry input, and 2 subtracts b from a. Each wraps modulo 256 and enables all four flags. C is the carry out of bit 7, or the borrow for subtract. V is signed two's-complement overflow. So 200+100 gives 44 with C=1, 44+100 with carry in gives 145 with C=0, and 1-3 gives 0xFE with N=1 and C=1.
- R4: Opcode 3 (increment) and opcode 4 (decrement) enable only N, Z and V, so C is not committed. V is 1 only for an increment of 0x7F or a decrement of 0x80.
- R5: Opcodes 5, 6 and 7 give the bitwise and, or and exclusive-or of a and b. They enable only N, Z and V, with V=0.
- R6: Opcode 8 gives 0xFF minus a, enables all four flags, sets C=1 and clears V.
- R7: Opcode 9 shifts a left with 0 into bit 0 and bit 7 into C. Opcode 10 shifts a right with 0 into bit 7 and bit 0 into C.
- R8: Opcode 11 rotates a left with the carry input into bit 0 and bit 7 into C. Opcode 12 rotates a right with the carry input into bit 7 and bit 0 into C.
- R9: Shifts and rotates (opcodes 9 to 12) enable all four flags, with V = N xor C.
- R10: Opcodes 13 to 15 give a zero result, a zero mask and zero flags.
- R11: Outputs reflect the inputs sampled at the previous rising clock edge. Operand b and the carry input have no effect on operations that do not use them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand (destination register) |
| b_i | input | 8 | Second operand (register or immediate) |
| c_i | input | 1 | Current carry flag |
| res_o | output | 8 | Registered result |
| flags_o | output | 4 | Registered {N,Z,C,V} |
| fmask_o | output | 4 | Registered commit mask {N,Z,C,V} |

## Verification
The block holds no state beyond one output register. A wrong value inside it therefore shows on the very next cycle, as a bad result, a bad flag, or a mask that lets the status register commit a bit it should keep.

The sweep covers every operand value for the unary operations, and a dense grid for the binary ones, with both carry-in values. This exposes misplaced carry bits at the wrap points, overflow at the signed boundaries, and masks that leak the carry on increment and decrement.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_INC = 4'd3,
        OP_DEC = 4'd4,
        OP_AND = 4'd5,
        OP_OR  = 4'd6,
        OP_EOR = 4'd7,
        OP_COM = 4'd8,
        OP_LSL = 4'd9,
        OP_LSR = 4'd10,
        OP_ROL = 4'd11,
        OP_ROR = 4'd12
    } alu_op_e;

    // Bit order shared by flags and mask: {N,Z,C,V}
    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flag4_t;

    localparam flag4_t MASK_ALL  = '{n: 1'b1, z: 1'b1, c: 1'b1, v: 1'b1};
    localparam flag4_t MASK_NZV  = '{n: 1'b1, z: 1'b1, c: 1'b0, v: 1'b1};
    localparam flag4_t MASK_NONE = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0};

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             cout,
    output logic             ovf
);
    localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};
    localparam logic [WIDTH-1:0] MAX_POS  = ~MSB_ONLY;
    localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH:0] sum;

    always_comb begin
        unique case (op)
            OP_ADD:  sum = {1'b0, a} + {1'b0, b};
            OP_ADC:  sum = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
            OP_SUB:  sum = {1'b0, a} - {1'b0, b};
            OP_INC:  sum = {1'b0, a} + {1'b0, ONE};
            OP_DEC:  sum = {1'b0, a} - {1'b0, ONE};
            default: sum = '0;
        endcase
        res  = sum[WIDTH-1:0];
        cout = sum[WIDTH];
        unique case (op)
            OP_ADD, OP_ADC: ovf = (a[WIDTH-1] == b[WIDTH-1]) && (res[WIDTH-1] != a[WIDTH-1]);
            OP_SUB:         ovf = (a[WIDTH-1] != b[WIDTH-1]) && (res[WIDTH-1] != a[WIDTH-1]);
            OP_INC:         ovf = (a == MAX_POS);
            OP_DEC:         ovf = (a == MSB_ONLY);
            default:        ovf = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] res,
    output logic             cout
);
    always_comb begin
        cout = 1'b0;
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_EOR:  res = a ^ b;
            OP_COM: begin
                res  = ~a;
                cout = 1'b1;
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic             cin,
    output logic [WIDTH-1:0] res,
    output logic             cout
);
    always_comb begin
        unique case (op)
            OP_LSL: begin
                res  = {a[WIDTH-2:0], 1'b0};
                cout = a[WIDTH-1];
            end
            OP_LSR: begin
                res  = {1'b0, a[WIDTH-1:1]};
                cout = a[0];
            end
            OP_ROL: begin
                res  = {a[WIDTH-2:0], cin};
                cout = a[WIDTH-1];
            end
            OP_ROR: begin
                res  = {cin, a[WIDTH-1:1]};
                cout = a[0];
            end
            default: begin
                res  = '0;
                cout = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             c_i,
    output logic [WIDTH-1:0] res_o,
    output logic [3:0]       flags_o,
    output logic [3:0]       fmask_o
);
    typedef struct packed {
        logic [WIDTH-1:0] res;
        flag4_t           flags;
        flag4_t           mask;
    } stage_t;

    alu_op_e          op;
    logic [WIDTH-1:0] as_res, bw_res, sh_res;
    logic             as_c, as_v, bw_c, sh_c;
    stage_t           stage_d, stage_q;

    assign op = alu_op_e'(op_i);

    alu8_addsub #(.WIDTH(WIDTH)) addsub_i (
        .op(op), .a(a_i), .b(b_i), .cin(c_i),
        .res(as_res), .cout(as_c), .ovf(as_v)
    );

    alu8_bitwise #(.WIDTH(WIDTH)) bitwise_i (
        .op(op), .a(a_i), .b(b_i),
        .res(bw_res), .cout(bw_c)
    );

    alu8_shifter #(.WIDTH(WIDTH)) shifter_i (
        .op(op), .a(a_i), .cin(c_i),
        .res(sh_res), .cout(sh_c)
    );

    always_comb begin
        flag4_t raw;
        stage_d = '0;
        raw     = '0;
        unique case (op_i)
            OP_ADD, OP_ADC, OP_SUB: begin
                stage_d.res  = as_res;
                raw.c        = as_c;
                raw.v        = as_v;
                stage_d.mask = MASK_ALL;
            end
            OP_INC, OP_DEC: begin
                stage_d.res  = as_res;
                raw.v        = as_v;
                stage_d.mask = MASK_NZV;
            end
            OP_AND, OP_OR, OP_EOR: begin
                stage_d.res  = bw_res;
                stage_d.mask = MASK_NZV;
            end
            OP_COM: begin
                stage_d.res  = bw_res;
                raw.c        = bw_c;
                stage_d.mask = MASK_ALL;
            end
            OP_LSL, OP_LSR, OP_ROL, OP_ROR: begin
                stage_d.res  = sh_res;
                raw.c        = sh_c;
                raw.v        = sh_res[WIDTH-1] ^ sh_c;
                stage_d.mask = MASK_ALL;
            end
            default: begin
                stage_d.res  = '0;
                stage_d.mask = MASK_NONE;
            end
        endcase
        raw.n         = stage_d.res[WIDTH-1];
        raw.z         = (stage_d.res == '0);
        stage_d.flags = raw & stage_d.mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign res_o   = stage_q.res;
    assign flags_o = stage_q.flags;
    assign fmask_o = stage_q.mask;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       op_i,
    input logic [WIDTH-1:0] a_i,
    input logic             c_i,
    input logic [WIDTH-1:0] res_o,
    input logic [3:0]       flags_o,
    input logic [3:0]       fmask_o
);
    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (res_o == '0 && flags_o == '0 && fmask_o == '0)); // R1

    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        fmask_o[2] |-> (flags_o[2] == (res_o == '0))); // R2

    AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        fmask_o[3] |-> (flags_o[3] == res_o[WIDTH-1])); // R2

    AST_MASKED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o & ~fmask_o) == 4'b0); // R2

    AST_INCDEC_KEEP_C: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && ($past(op_i) == OP_INC || $past(op_i) == OP_DEC))
        |-> (fmask_o == 4'b1101)); // R4

    AST_COM_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == OP_COM)
        |-> (flags_o[1] && !flags_o[0] && res_o == ~$past(a_i))); // R6

    AST_LSL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == OP_LSL)
        |-> (!res_o[0] && flags_o[1] == $past(a_i[WIDTH-1]))); // R7

    AST_ROR_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) == OP_ROR)
        |-> (res_o[WIDTH-1] == $past(c_i) && flags_o[1] == $past(a_i[0]))); // R8

    AST_SHIFT_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) >= 4'd9 && $past(op_i) <= 4'd12)
        |-> (flags_o[0] == (flags_o[3] ^ flags_o[1]))); // R9

    AST_BAD_OP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(op_i) >= 4'd13)
        |-> (res_o == '0 && fmask_o == 4'b0)); // R10
endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .c_i(c_i),
    .res_o(res_o), .flags_o(flags_o), .fmask_o(fmask_o)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] a_i = '0;
    logic [7:0] b_i = '0;
    logic       c_i = 1'b0;
    logic [7:0] res_o;
    logic [3:0] flags_o;
    logic [3:0] fmask_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    alu8_core #(.WIDTH(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i), .c_i(c_i),
        .res_o(res_o), .flags_o(flags_o), .fmask_o(fmask_o)
    );

    // Reference model: returns {res[15:8], flags[7:4], mask[3:0]}
    function automatic logic [15:0] model(int op, int a, int b, int c);
        int r = 0, s;
        int cf = 0, vf = 0, nf, zf;
        logic [3:0] m = 4'b0000;
        case (op)
            0, 1: begin
                s  = a + b + ((op == 1) ? c : 0);
                r  = s % 256;
                cf = (s > 255) ? 1 : 0;
                vf = (((a ^ r) & (b ^ r) & 128) != 0) ? 1 : 0;
                m  = 4'b1111;
            end
            2: begin
                r  = (a - b + 256) % 256;
                cf = (a < b) ? 1 : 0;
                vf = (((a ^ b) & (a ^ r) & 128) != 0) ? 1 : 0;
                m  = 4'b1111;
            end
            3: begin r = (a + 1) % 256;   vf = (a == 127) ? 1 : 0; m = 4'b1101; end
            4: begin r = (a + 255) % 256; vf = (a == 128) ? 1 : 0; m = 4'b1101; end
            5: begin r = a & b; m = 4'b1101; end
            6: begin r = a | b; m = 4'b1101; end
            7: begin r = a ^ b; m = 4'b1101; end
            8: begin r = 255 - a; cf = 1; m = 4'b1111; end
            9:  begin r = (a * 2) % 256;     cf = a / 128; m = 4'b1111; end
            10: begin r = a / 2;             cf = a % 2;   m = 4'b1111; end
            11: begin r = (a * 2) % 256 + c; cf = a / 128; m = 4'b1111; end
            12: begin r = a / 2 + c * 128;   cf = a % 2;   m = 4'b1111; end
            default: begin r = 0; m = 4'b0000; end
        endcase
        nf = (r >= 128) ? 1 : 0;
        zf = (r == 0) ? 1 : 0;
        if (op >= 9 && op <= 12) vf = nf ^ cf;
        return {r[7:0], (4'({nf[0], zf[0], cf[0], vf[0]}) & m), m};
    endfunction

    function automatic string tag_of(int op);
        case (op)
            0, 1, 2:       return "R3";
            3, 4:          return "R4";
            5, 6, 7:       return "R5";
            8:             return "R6";
            9, 10:         return "R7/R9";
            11, 12:        return "R8/R9";
            default:       return "R10";
        endcase
    endfunction

    // R11: drive at a falling edge, check at the next falling edge (one register)
    task automatic run_vec(int op, int a, int b, int c, string tag);
        logic [15:0] exp;
        @(negedge clk);
        op_i = 4'(op); a_i = 8'(a); b_i = 8'(b); c_i = 1'(c);
        exp = model(op, a, b, c);
        @(negedge clk);
        n_checks++;
        if ({res_o, flags_o, fmask_o} !== exp) begin
            n_fails++;
            $display("FAIL %s R2 R11 op=%0d a=%0d b=%0d c=%0d: got res=%0d flags=%b mask=%b, expected res=%0d flags=%b mask=%b",
                     tag, op, a, b, c, res_o, flags_o, fmask_o, exp[15:8], exp[7:4], exp[3:0]);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin : stim
        op_i = 4'd0; a_i = 8'd200; b_i = 8'd100; c_i = 1'b1;
        repeat (3) @(negedge clk);
        n_checks++;
        if (res_o !== 8'd0 || flags_o !== 4'd0 || fmask_o !== 4'd0) begin
            n_fails++;
            $display("FAIL R1 reset: got res=%0d flags=%b mask=%b, expected 0 0 0",
                     res_o, flags_o, fmask_o);
        end
        rst_n = 1'b1;

        // Worked examples, R3
        run_vec(0, 200, 100, 0, "R3 add wrap");
        run_vec(1, 44, 100, 1, "R3 adc");
        run_vec(2, 1, 3, 0, "R3 sub borrow");
        run_vec(3, 127, 0, 1, "R4 inc ovf");
        run_vec(4, 128, 0, 0, "R4 dec ovf");
        run_vec(8, 0, 0, 0, "R6 com");

        // Unary ops: every operand, both carry values; b varied to prove it is unused (R11)
        for (int op = 3; op <= 12; op++) begin
            if (op >= 5 && op <= 7) continue;
            for (int c = 0; c < 2; c++)
                for (int a = 0; a < 256; a++)
                    run_vec(op, a, (a * 37 + c) % 256, c, tag_of(op));
        end

        // Binary ops: all a, grid of b, both carries
        for (int op = 0; op <= 7; op++) begin
            if (op == 3 || op == 4) continue;
            for (int c = 0; c < 2; c++)
                for (int a = 0; a < 256; a++)
                    for (int b = 0; b < 256; b += 17)
                        run_vec(op, a, b, c, tag_of(op));
        end

        // Unused opcodes, R10
        for (int op = 13; op <= 15; op++)
            for (int a = 0; a < 256; a += 51)
                run_vec(op, a, 255 - a, a % 2, "R10");

        finish_run();
    end
endmodule